// File: doc/BRIEF.md
# Ramp Offset Calibration Controller

This block removes the DC offset between the ramps of a multi-ramp column converter, using only digital means. Each ramp comes from its own DAC, whose 12-bit start code the block holds. On a start request the block walks through every ramp except ramp 0, which is the reference, in ascending order. For each one it drives a test-voltage code that lies halfway into that ramp's span, and a dedicated test column converts that voltage repeatedly.

The test column reports a coarse ramp index and a fine count for each conversion. When the coarse index names the ramp under calibration, the block adds the fine count's deviation from the mid-code to a signed accumulator. When it names any other ramp, the block drops the sample and counts it as bad. After a power-of-two number of accepted samples, the mean deviation is scaled into DAC steps and subtracted from that ramp's start code, with saturation. The walk then moves on to the next ramp.

Too many bad samples on one ramp end the run early and raise an error flag. A finished or aborted run pulses a done strobe.

Top module: `ramp_offset_cal`

## Requirements
- R1: After reset, the start code of ramp k is k*RAMP_PITCH (480 by default), and busy_o, done_o, err_o and meas_en_o are all 0.
- R2: A start_i sampled while idle begins a run. From the next cycle, busy_o=1, meas_en_o=1 and cal_ramp_o=1.
- R3: While a ramp is being measured, test_code_o equals that ramp's start code plus HALF_SPAN (256), saturated at 4095.
- R4: A sample with smp_valid_i=1, meas_en_o=1 and smp_coarse_i==cal_ramp_o adds smp_fine_i-MID_CODE (MID_CODE=128) to the accumulator. After AVG_N=16 accepted samples, the mean is floor(sum/16).
- R5: At the end of a ramp's measurement, its new start code is old - mean*GAIN (GAIN=2), clamped to 0..4095. No other code changes, and ramp 0 never changes.
- R6: Ramps are measured in the order 1,2,...,7. The cycle after ramp 7's code is written, done_o is 1 for exactly one cycle, with busy_o=0.
- R7: A valid sample whose coarse index differs from cal_ramp_o is discarded. The fourth such sample (MAX_BAD=4) on one ramp aborts the run: done_o pulses, busy_o drops, and err_o goes to 1 and stays there until the next start. The aborted ramp's code is left unchanged. Three bad samples on a ramp do not abort.
- R8: start_i while busy has no effect. smp_valid_i while meas_en_o=0 has no effect.
- R9: If start_i is still high in the cycle where done_o pulses, a new run begins, and busy_o and meas_en_o are 1 again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run request, taken only when idle |
| smp_valid_i | input | 1 | Test column result strobe |
| smp_coarse_i | input | 3 | Coarse ramp index reported by the test column |
| smp_fine_i | input | 8 | Fine count reported by the test column |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run or an abort |
| err_o | output | 1 | Last run aborted on bad samples |
| meas_en_o | output | 1 | Samples are accepted in this cycle |
| cal_ramp_o | output | 3 | Ramp under calibration |
| test_code_o | output | 12 | DAC code for the test voltage |
| start_codes_o | output | 96 | Start codes of all ramps, ramp k at bits [12k+11:12k] |

## Verification
The end of one run and the acceptance of the next start can fall in the same cycle. This happens when start_i is still high at the moment done_o pulses. The bench provokes it by holding start_i high through a whole run. It then judges two things: that the start codes written by the first run match the model, and that busy_o is low for exactly the done cycle before the second run reports ramp 1 again. Bad samples at the abort limit and samples that arrive in the update cycle are also mixed in, and each is judged through the final start codes.

// File: rtl/ramp_cal_pkg.sv
package ramp_cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MEAS   = 2'd1,
    ST_UPDATE = 2'd2
  } cal_state_e;

  function automatic int clamp_int(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/ramp_code_bank.sv
module ramp_code_bank #(
  parameter int NUM_RAMPS  = 8,
  parameter int CODE_W     = 12,
  parameter int RAMP_PITCH = 480,
  localparam int IDX_W     = $clog2(NUM_RAMPS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [CODE_W-1:0]           wr_code_i,
  output logic [NUM_RAMPS*CODE_W-1:0] codes_o
);

  for (genvar k = 0; k < NUM_RAMPS; k++) begin : g_ramp
    localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(k * RAMP_PITCH);
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q <= RST_CODE;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(k)) && (k != 0)) begin
        code_q <= wr_code_i;
      end
    end

    assign codes_o[k*CODE_W +: CODE_W] = code_q;
  end

endmodule

// File: rtl/cal_err_accum.sv
module cal_err_accum #(
  parameter int FINE_W   = 8,
  parameter int AVG_LOG2 = 4,
  parameter int MID_CODE = 128,
  localparam int ACC_W   = FINE_W + 1 + AVG_LOG2,
  localparam int CNT_W   = AVG_LOG2 + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    add_i,
  input  logic [FINE_W-1:0]       fine_i,
  output logic                    last_o,
  output logic signed [ACC_W-1:0] avg_o
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'((1 << AVG_LOG2) - 1);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] dev;
  logic [CNT_W-1:0]        cnt_q;

  assign dev    = $signed(ACC_W'(fine_i)) - $signed(ACC_W'(MID_CODE));
  assign last_o = add_i && (cnt_q == LAST_CNT);
  assign avg_o  = acc_q >>> AVG_LOG2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (add_i) begin
      acc_q <= acc_q + dev;
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cal_code_math.sv
module cal_code_math #(
  parameter int CODE_W    = 12,
  parameter int ACC_W     = 13,
  parameter int GAIN      = 2,
  parameter int HALF_SPAN = 256
) (
  input  logic [CODE_W-1:0]       cur_code_i,
  input  logic signed [ACC_W-1:0] avg_i,
  output logic [CODE_W-1:0]       new_code_o,
  output logic [CODE_W-1:0]       test_code_o
);
  import ramp_cal_pkg::*;

  localparam int CODE_MAX = (1 << CODE_W) - 1;

  int upd_v;
  int tst_v;

  always_comb begin
    upd_v       = int'(cur_code_i) - int'(avg_i) * GAIN;
    tst_v       = int'(cur_code_i) + HALF_SPAN;
    new_code_o  = CODE_W'(clamp_int(upd_v, CODE_MAX));
    test_code_o = CODE_W'(clamp_int(tst_v, CODE_MAX));
  end

endmodule

// File: rtl/cal_fsm.sv
module cal_fsm #(
  parameter int NUM_RAMPS = 8,
  parameter int MAX_BAD   = 4,
  localparam int IDX_W    = $clog2(NUM_RAMPS),
  localparam int BAD_W    = $clog2(MAX_BAD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             smp_valid_i,
  input  logic [IDX_W-1:0] smp_coarse_i,
  input  logic             acc_last_i,
  output logic             acc_clr_o,
  output logic             acc_add_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] ramp_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             meas_o
);
  import ramp_cal_pkg::*;

  localparam logic [IDX_W-1:0] LAST_RAMP = IDX_W'(NUM_RAMPS - 1);
  localparam logic [BAD_W-1:0] BAD_LIM   = BAD_W'(MAX_BAD - 1);

  cal_state_e       state_q;
  logic [IDX_W-1:0] ramp_q;
  logic [BAD_W-1:0] bad_q;
  logic             done_q, err_q;
  logic             hit, miss;

  assign meas_o    = (state_q == ST_MEAS);
  assign hit       = meas_o && smp_valid_i && (smp_coarse_i == ramp_q);
  assign miss      = meas_o && smp_valid_i && (smp_coarse_i != ramp_q);
  assign acc_add_o = hit;
  assign acc_clr_o = ((state_q == ST_IDLE) && start_i) || (state_q == ST_UPDATE);
  assign wr_en_o   = (state_q == ST_UPDATE);
  assign ramp_o    = ramp_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ramp_q  <= '0;
      bad_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_MEAS;
            ramp_q  <= IDX_W'(1);
            bad_q   <= '0;
            err_q   <= 1'b0;
          end
        end
        ST_MEAS: begin
          if (hit && acc_last_i) begin
            state_q <= ST_UPDATE;
          end else if (miss) begin
            if (bad_q == BAD_LIM) begin
              state_q <= ST_IDLE;
              err_q   <= 1'b1;
              done_q  <= 1'b1;
            end else begin
              bad_q <= bad_q + 1'b1;
            end
          end
        end
        ST_UPDATE: begin
          if (ramp_q == LAST_RAMP) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_MEAS;
            ramp_q  <= ramp_q + 1'b1;
            bad_q   <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ramp_offset_cal.sv
module ramp_offset_cal #(
  parameter int NUM_RAMPS  = 8,
  parameter int CODE_W     = 12,
  parameter int FINE_W     = 8,
  parameter int AVG_LOG2   = 4,
  parameter int GAIN       = 2,
  parameter int HALF_SPAN  = 256,
  parameter int RAMP_PITCH = 480,
  parameter int MAX_BAD    = 4,
  localparam int IDX_W     = $clog2(NUM_RAMPS),
  localparam int MID_CODE  = 1 << (FINE_W - 1),
  localparam int ACC_W     = FINE_W + 1 + AVG_LOG2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        smp_valid_i,
  input  logic [IDX_W-1:0]            smp_coarse_i,
  input  logic [FINE_W-1:0]           smp_fine_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        err_o,
  output logic                        meas_en_o,
  output logic [IDX_W-1:0]            cal_ramp_o,
  output logic [CODE_W-1:0]           test_code_o,
  output logic [NUM_RAMPS*CODE_W-1:0] start_codes_o
);

  logic                    acc_clr, acc_add, acc_last, wr_en;
  logic [IDX_W-1:0]        ramp;
  logic signed [ACC_W-1:0] avg;
  logic [CODE_W-1:0]       cur_code, new_code;

  cal_fsm #(
    .NUM_RAMPS(NUM_RAMPS),
    .MAX_BAD  (MAX_BAD)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .smp_valid_i (smp_valid_i),
    .smp_coarse_i(smp_coarse_i),
    .acc_last_i  (acc_last),
    .acc_clr_o   (acc_clr),
    .acc_add_o   (acc_add),
    .wr_en_o     (wr_en),
    .ramp_o      (ramp),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .meas_o      (meas_en_o)
  );

  cal_err_accum #(
    .FINE_W  (FINE_W),
    .AVG_LOG2(AVG_LOG2),
    .MID_CODE(MID_CODE)
  ) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (acc_clr),
    .add_i (acc_add),
    .fine_i(smp_fine_i),
    .last_o(acc_last),
    .avg_o (avg)
  );

  ramp_code_bank #(
    .NUM_RAMPS (NUM_RAMPS),
    .CODE_W    (CODE_W),
    .RAMP_PITCH(RAMP_PITCH)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (ramp),
    .wr_code_i(new_code),
    .codes_o  (start_codes_o)
  );

  assign cur_code = start_codes_o[ramp*CODE_W +: CODE_W];

  cal_code_math #(
    .CODE_W   (CODE_W),
    .ACC_W    (ACC_W),
    .GAIN     (GAIN),
    .HALF_SPAN(HALF_SPAN)
  ) u_math (
    .cur_code_i (cur_code),
    .avg_i      (avg),
    .new_code_o (new_code),
    .test_code_o(test_code_o)
  );

  assign cal_ramp_o = ramp;

endmodule

// File: rtl/ramp_offset_cal_chk.sv
module ramp_offset_cal_chk #(
  parameter int NUM_RAMPS = 8,
  parameter int CODE_W    = 12,
  localparam int IDX_W    = $clog2(NUM_RAMPS)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        start_i,
  input logic                        busy_o,
  input logic                        done_o,
  input logic                        err_o,
  input logic                        meas_en_o,
  input logic [IDX_W-1:0]            cal_ramp_o,
  input logic [NUM_RAMPS*CODE_W-1:0] start_codes_o
);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  // R8
  meas_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_en_o |-> busy_o);

  // R6
  ramp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cal_ramp_o != '0));

  // R2
  start_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && meas_en_o && cal_ramp_o == IDX_W'(1)));

  // R5
  ref_ramp_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(start_codes_o[CODE_W-1:0]));

  for (genvar k = 1; k < NUM_RAMPS; k++) begin : g_wr
    // R5
    only_cal_ramp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(start_codes_o[k*CODE_W +: CODE_W]) |->
        ($past(busy_o) && $past(cal_ramp_o) == IDX_W'(k)));
  end

endmodule

bind ramp_offset_cal ramp_offset_cal_chk #(
  .NUM_RAMPS(NUM_RAMPS),
  .CODE_W   (CODE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .meas_en_o    (meas_en_o),
  .cal_ramp_o   (cal_ramp_o),
  .start_codes_o(start_codes_o)
);

// File: tb/ramp_offset_cal_tb.sv
module ramp_offset_cal_tb;

  localparam int NR = 8, CW = 12, FW = 8, AVG_N = 16, GAIN = 2, HALF = 256;
  localparam int PITCH = 480, MID = 128, CMAX = 4095;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, smp_valid_i = 1'b0;
  logic [2:0] smp_coarse_i = '0;
  logic [FW-1:0] smp_fine_i = '0;
  logic busy_o, done_o, err_o, meas_en_o;
  logic [2:0] cal_ramp_o;
  logic [CW-1:0] test_code_o;
  logic [NR*CW-1:0] start_codes_o;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  int exp_code [NR];

  always #2.5 clk_i = ~clk_i;

  ramp_offset_cal u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .smp_valid_i(smp_valid_i), .smp_coarse_i(smp_coarse_i), .smp_fine_i(smp_fine_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .meas_en_o(meas_en_o),
    .cal_ramp_o(cal_ramp_o), .test_code_o(test_code_o), .start_codes_o(start_codes_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampi(input int v);
    return (v < 0) ? 0 : (v > CMAX) ? CMAX : v;
  endfunction

  function automatic int floor_avg(input int sum);
    if (sum >= 0) return sum / AVG_N;
    return -((-sum + AVG_N - 1) / AVG_N);
  endfunction

  function automatic int dut_code(input int k);
    return int'(start_codes_o[k*CW +: CW]);
  endfunction

  task automatic check_codes(input string req);
    for (int k = 0; k < NR; k++) check(dut_code(k) == exp_code[k], req, dut_code(k), exp_code[k]);
  endtask

  // kind 0: random offsets with noise, 1: fine always 255, 2: fine always 0
  task automatic run_once(input int kind, input int abort_ramp, input bit hold, input bit issue_start);
    int k = 1, good = 0, bad = 0, sum = 0, cyc = 0, fine;
    int off [NR];
    bit exp_abort = 1'b0, first = 1'b1;
    for (int r = 0; r < NR; r++) off[r] = int'($urandom % 41) - 20;
    if (issue_start) begin
      @(negedge clk_i);
      start_i = 1'b1;
    end
    forever begin
      @(negedge clk_i);
      smp_valid_i = 1'b0;
      if (!hold) start_i = 1'b0;
      cyc++;
      if (cyc > 3000) begin
        check(1'b0, "R6 run timeout", cyc, 0);
        break;
      end
      if (done_o) break;
      if (first) begin
        check(busy_o && meas_en_o && cal_ramp_o == 3'd1, "R2 run entry", int'(cal_ramp_o), 1);
        first = 1'b0;
      end
      if (meas_en_o) begin
        if (good == 0 && bad == 0) begin
          check(int'(cal_ramp_o) == k, "R6 ramp order", int'(cal_ramp_o), k);
          check(int'(test_code_o) == clampi(exp_code[k] + HALF), "R3 test code",
                int'(test_code_o), clampi(exp_code[k] + HALF));
        end
        smp_valid_i = 1'b1;
        if (k == abort_ramp || (abort_ramp == 0 && bad < 3 && ($urandom % 8) == 0)) begin
          smp_coarse_i = 3'((k + 1 + int'($urandom % 7)) % NR);
          smp_fine_i   = FW'($urandom);
          bad++;
          if (bad == 4) exp_abort = 1'b1;
        end else begin
          if (kind == 1) fine = 255;
          else if (kind == 2) fine = 0;
          else begin
            fine = MID + off[k] + int'($urandom % 7) - 3;
            fine = (fine < 0) ? 0 : (fine > 255) ? 255 : fine;
          end
          smp_coarse_i = 3'(k);
          smp_fine_i   = FW'(fine);
          sum += fine - MID;
          good++;
          if (good == AVG_N) begin
            exp_code[k] = clampi(exp_code[k] - floor_avg(sum) * GAIN);
            k++; good = 0; bad = 0; sum = 0;
          end
        end
        if (!hold && busy_o && ($urandom % 16) == 0) start_i = 1'b1;
      end else if (($urandom % 2) == 0) begin
        // R8: sample in update cycle must be dropped
        smp_valid_i  = 1'b1;
        smp_coarse_i = cal_ramp_o;
        smp_fine_i   = 8'd255;
      end
    end
    check(!busy_o && !meas_en_o, "R6 idle at done", int'(busy_o), 0);
    check(err_o == exp_abort, "R7 error flag", int'(err_o), int'(exp_abort));
    check_codes(exp_abort ? "R7 codes after abort" : "R5 codes after run");
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    check(!done_o, "R6 done width", int'(done_o), 0);
    if (hold) begin
      check(busy_o && meas_en_o && cal_ramp_o == 3'd1, "R9 back-to-back start", int'(busy_o), 1);
      start_i = 1'b0;
    end else begin
      check(!busy_o, "R8 stays idle", int'(busy_o), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < NR; k++) exp_code[k] = k * PITCH;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !err_o && !meas_en_o, "R1 reset flags", int'(busy_o), 0);
    check_codes("R1 reset codes");

    // R8: samples while idle
    repeat (4) begin
      @(negedge clk_i);
      smp_valid_i = 1'b1; smp_coarse_i = 3'd1; smp_fine_i = 8'd0;
    end
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    check(!busy_o, "R8 idle sample", int'(busy_o), 0);
    check_codes("R8 idle codes");

    // R4 R5: random offsets
    repeat (3) run_once(0, 0, 1'b0, 1'b1);
    // R5: low saturation on ramp 1
    repeat (3) run_once(1, 0, 1'b0, 1'b1);
    // R5 R3: high saturation on upper ramps
    repeat (6) run_once(2, 0, 1'b0, 1'b1);
    // R7: abort on ramp 3, then a clean run clears the flag
    run_once(0, 3, 1'b0, 1'b1);
    run_once(0, 0, 1'b0, 1'b1);
    // R9: start held across done
    run_once(0, 0, 1'b1, 1'b1);
    run_once(0, 0, 1'b0, 1'b0);
    // R7: abort on the last ramp
    run_once(0, 7, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk_i) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule